// File: doc/BRIEF.md
# Chained FIFO Depth-Expansion Controller

This block is the ownership logic of one slice in a ring of identical FIFO slices. When several slices are chained to build a deeper queue, only one slice accepts writes at a time, and only one slice serves reads at a time. That right is a token. There is one token for writing and one for reading. All slices see the same write, read and retransmit strobes. Each slice passes only the strobes it holds a token for on to its own storage, as local enables with local addresses.

When a slice writes its last location, it puts a one-cycle code on its expansion output, and the next slice in the ring takes the write token at the same clock edge. A read from the last location hands the read token on in the same way. The slice whose first-slice input is high owns both tokens after reset. The other slices own none, and their pointers rest at zero.

The expansion input can instead be tied to the value 2'b11. The slice samples this while reset is held and then runs alone. In that mode it keeps a fill count. It blocks writes when full and reads when empty, and it supports retransmit. The expansion output then reports half-full.

Top module: `exp_chain_ctl`

## Requirements
- R1: While reset is held, a slice samples its expansion input: 2'b11 selects single mode, any other value selects chained mode. After reset, a chained slice with first_slice high owns both tokens, other slices own none, and both addresses are 0.
- R2: In chained mode, wr_en follows wr_req only while the slice owns the write token, and rd_en follows rd_req only while it owns the read token. Otherwise the enable stays 0.
- R3: Each enabled strobe advances its address by one at the clock edge, and the address wraps from DEPTH-1 to 0.
- R4: In chained mode, an enabled write at address DEPTH-1 sets exp_out bit 0 in that same cycle. The slice loses the write token at the edge that ends the cycle.
- R5: In chained mode, an enabled read at address DEPTH-1 sets exp_out bit 1 in the same way, with the same loss of the read token. When both happen together, exp_out is 2'b11.
- R6: In chained mode, exp_in bit 0 high gives the slice the write token at the next edge, and exp_in bit 1 high gives it the read token.
- R7: Each exp_out bit in chained mode is high for exactly one cycle per wrap.
- R8: In chained mode, a slice that does not own a token keeps the matching address at 0.
- R9: In single mode, exp_out bit 1 is 0. Bit 0 is 1 while the fill count is above DEPTH/2 and 0 while it is at or below DEPTH/2.
- R10: In single mode, wr_en is 0 while the fill count equals DEPTH, and rd_en is 0 while the count is 0.
- R11: In single mode, rt_req blocks both enables in its cycle. It sets the read address to 0 and the fill count to the current write address, so the stored data can be read again when fewer than DEPTH writes have occurred since reset.
- R12: In chained mode, rt_req has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also the window in which the mode is sampled |
| first_slice | input | 1 | High on the slice that owns both tokens after reset |
| exp_in | input | 2 | Token code from the previous slice (bit 0 write, bit 1 read), or 2'b11 tie-off for single mode |
| wr_req | input | 1 | Shared write strobe, one write per high cycle |
| rd_req | input | 1 | Shared read strobe, one read per high cycle |
| rt_req | input | 1 | Retransmit request, used in single mode only |
| wr_en | output | 1 | Local write enable to the storage |
| rd_en | output | 1 | Local read enable to the storage |
| wr_addr | output | $clog2(DEPTH) | Local write address |
| rd_addr | output | $clog2(DEPTH) | Local read address |
| exp_out | output | 2 | Token code to the next slice, or {0, half-full} in single mode |

## Verification
The bench builds every instance with DEPTH=4. This makes each wrap only four strobes long, so a short run passes both tokens all the way round a two-slice ring and back. The same run includes a cycle where both tokens leave together and a retransmit attempt in chained mode. A third instance, also at DEPTH=4, is tied off in single mode. With a half-full threshold of 2, its sequence reaches the threshold in both directions, reaches full and empty, and runs a retransmit after three writes, all within a few dozen cycles.

// File: rtl/exp_chain_pkg.sv
// Shared codes for the chained FIFO expansion controller.
// Assumes: bit 0 of the expansion code carries the write token and
// bit 1 carries the read token; the all-ones code doubles as the
// single-mode tie-off, sampled only while reset is held.
package exp_chain_pkg;

    typedef enum logic [1:0] {
        XFER_IDLE = 2'b00,
        XFER_WR   = 2'b01,
        XFER_RD   = 2'b10,
        XFER_BOTH = 2'b11
    } xfer_e;

    localparam logic [1:0] SOLO_TIE = XFER_BOTH;

    localparam int LANE_WR = 0;
    localparam int LANE_RD = 1;
    localparam int LANES   = 2;

endpackage

// File: rtl/exp_ptr.sv
// Local address pointer for one lane (write or read) of a slice.
// Advances by one on each step, wraps from DEPTH-1 to 0, and can be
// cleared to the first location. Assumes DEPTH >= 2.
module exp_ptr #(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step,
    input  logic                     clear,
    output logic [$clog2(DEPTH)-1:0] ptr,
    output logic                     at_last
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    // Flags the final location of the local storage.
    assign at_last = (ptr == LAST);

    // Pointer register: reset, clear, or advance with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (clear) begin
            ptr <= '0;
        end else if (step) begin
            ptr <= at_last ? '0 : ptr + 1'b1;
        end
    end

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        step && at_last && !clear |=> ptr == '0); // R3
    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        step && !at_last && !clear |=> ptr == $past(ptr) + 1'b1); // R3

endmodule

// File: rtl/exp_token.sv
// Ownership token for one lane of a slice. Loads its initial state
// during reset, is gained when the previous slice hands it over and
// is lost when this slice hands it on. Receiving wins over giving,
// so a ring of one slice keeps its own token.
module exp_token (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic take,
    input  logic give,
    output logic own
);
    // Token register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own <= init;
        end else if (take) begin
            own <= 1'b1;
        end else if (give) begin
            own <= 1'b0;
        end
    end

    AST_TOKEN_GIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        own && give && !take |=> !own); // R4
    AST_TOKEN_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> own); // R6

endmodule

// File: rtl/exp_fill.sv
// Fill counter for single-mode operation. Tracks the number of stored
// words and reports full, empty and above-half. It can be reloaded
// for retransmit. Assumes the caller never raises inc when full or
// dec when empty.
module exp_fill #(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       inc,
    input  logic                       dec,
    input  logic                       reload,
    input  logic [$clog2(DEPTH+1)-1:0] reload_val,
    output logic                       full,
    output logic                       empty,
    output logic                       half
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

    logic [CW-1:0] count;

    // Status decode from the stored count.
    assign full  = (count == FULL_CNT);
    assign empty = (count == '0);
    assign half  = (count > HALF_CNT);

    // Count register: reload, or net change from this cycle's strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (reload) begin
            count <= reload_val;
        end else begin
            case ({inc, dec})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !inc); // R10
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !dec); // R10

endmodule

// File: rtl/exp_chain_ctl.sv
// Depth-expansion controller for one slice of a FIFO ring.
// Chained mode: the slice gates the shared strobes with a write token
// and a read token. It pulses exp_out for one cycle when a lane wraps
// and hands that token to the next slice at the same edge.
// Single mode (exp_in tied to 2'b11 during reset): the slice owns both
// lanes, guards full and empty, supports retransmit, and shows
// half-full on exp_out[0].
// Assumes DEPTH >= 2, strobes low while reset is held, and external
// logic that prevents overflow and underflow across a chained ring.
module exp_chain_ctl
    import exp_chain_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     first_slice,
    input  logic [1:0]               exp_in,
    input  logic                     wr_req,
    input  logic                     rd_req,
    input  logic                     rt_req,
    output logic                     wr_en,
    output logic                     rd_en,
    output logic [$clog2(DEPTH)-1:0] wr_addr,
    output logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [1:0]               exp_out
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic             solo_q;
    logic             rt_blk;
    logic             full;
    logic             empty;
    logic             half;
    logic [LANES-1:0] lane_req;
    logic [LANES-1:0] lane_room;
    logic [LANES-1:0] lane_own;
    logic [LANES-1:0] lane_en;
    logic [LANES-1:0] lane_last;
    logic [LANES-1:0] lane_take;
    logic [LANES-1:0] lane_pass;
    logic [AW-1:0]    lane_ptr [LANES];

    // Mode register: latches the tie-off code only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            solo_q <= (exp_in == SOLO_TIE);
        end
    end

    // Retransmit applies only in single mode and blocks that cycle's strobes.
    assign rt_blk = solo_q & rt_req;

    // Per-lane request and room vectors (index 0 write, 1 read).
    assign lane_req  = {rd_req, wr_req};
    assign lane_room = {~empty, ~full};

    // Enables: token ownership in chained mode, room checks in single mode.
    assign lane_en = {LANES{rst_n & ~rt_blk}} & lane_req
                   & (solo_q ? lane_room : lane_own);

    // Incoming tokens and outgoing wrap pulses, chained mode only.
    assign lane_take = {LANES{~solo_q}} & exp_in;
    assign lane_pass = {LANES{~solo_q}} & lane_en & lane_last;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            exp_token u_tok (
                .clk   (clk),
                .rst_n (rst_n),
                .init  (first_slice),
                .take  (lane_take[g]),
                .give  (lane_pass[g]),
                .own   (lane_own[g])
            );

            exp_ptr #(.DEPTH(DEPTH)) u_ptr (
                .clk     (clk),
                .rst_n   (rst_n),
                .step    (lane_en[g]),
                .clear   ((g == LANE_RD) ? rt_blk : 1'b0),
                .ptr     (lane_ptr[g]),
                .at_last (lane_last[g])
            );
        end
    endgenerate

    exp_fill #(.DEPTH(DEPTH)) u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc        (solo_q & lane_en[LANE_WR]),
        .dec        (solo_q & lane_en[LANE_RD]),
        .reload     (rt_blk),
        .reload_val (CW'(lane_ptr[LANE_WR])),
        .full       (full),
        .empty      (empty),
        .half       (half)
    );

    // Output mapping; exp_out is quiet during reset so neighbours see chained mode.
    assign wr_en   = lane_en[LANE_WR];
    assign rd_en   = lane_en[LANE_RD];
    assign wr_addr = lane_ptr[LANE_WR];
    assign rd_addr = lane_ptr[LANE_RD];
    assign exp_out = !rst_n ? XFER_IDLE : (solo_q ? {1'b0, half} : lane_pass);

    AST_WR_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !solo_q && exp_out[0] |=> !exp_out[0]); // R7
    AST_RD_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !solo_q && exp_out[1] |=> !exp_out[1]); // R7
    AST_IDLE_WR_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        !solo_q && !lane_own[LANE_WR] |-> wr_addr == '0); // R8
    AST_IDLE_RD_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        !solo_q && !lane_own[LANE_RD] |-> rd_addr == '0); // R8
    AST_RT_CHAINED: assert property (@(posedge clk) disable iff (!rst_n)
        !solo_q && rt_req && !rd_en |=> $stable(rd_addr)); // R12
    AST_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        solo_q && exp_out[0] && !rd_en && !rt_req |=> exp_out[0]); // R9

endmodule

// File: tb/sim_exp_chain_ctl.sv
`timescale 1ns/1ps
module sim_exp_chain_ctl;

    localparam int DEPTH = 4;
    localparam int AW    = $clog2(DEPTH);

    typedef struct packed {
        logic          wr, rd, rt;
        logic          we0, re0, we1, re1;
        logic [1:0]    xo0, xo1;
        logic [AW-1:0] wa0, wa1, ra0, ra1;
    } vec_t;

    // Two-slice ring walk; u0 is first, u1 receives from u0 and feeds u0.
    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{1,0,0, 1,0,0,0, 0,0, 0,0,0,0},
        '{1,0,0, 1,0,0,0, 0,0, 1,0,0,0},
        '{1,0,0, 1,0,0,0, 0,0, 2,0,0,0},
        '{1,0,0, 1,0,0,0, 1,0, 3,0,0,0},
        '{1,0,0, 0,0,1,0, 0,0, 0,0,0,0},
        '{0,1,0, 0,1,0,0, 0,0, 0,1,0,0},
        '{1,1,0, 0,1,1,0, 0,0, 0,1,1,0},
        '{0,0,1, 0,0,0,0, 0,0, 0,2,2,0},
        '{0,1,0, 0,1,0,0, 0,0, 0,2,2,0},
        '{1,1,0, 0,1,1,0, 2,0, 0,2,3,0},
        '{1,1,0, 0,0,1,1, 0,1, 0,3,0,0},
        '{1,0,0, 1,0,0,0, 0,0, 0,0,0,1},
        '{0,1,0, 0,0,0,1, 0,0, 1,0,0,1},
        '{0,1,0, 0,0,0,1, 0,0, 1,0,0,2},
        '{0,1,0, 0,0,0,1, 0,2, 1,0,0,3},
        '{0,1,0, 0,1,0,0, 0,0, 1,0,0,0},
        '{1,1,0, 1,1,0,0, 0,0, 1,0,1,0},
        '{1,1,0, 1,1,0,0, 0,0, 2,0,2,0},
        '{1,1,0, 1,1,0,0, 3,0, 3,0,3,0},
        '{1,1,0, 0,0,1,1, 0,0, 0,0,0,0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_req = 1'b0, rd_req = 1'b0, rt_req = 1'b0;
    logic s_wr = 1'b0, s_rd = 1'b0, s_rt = 1'b0;
    logic we0, re0, we1, re1, swe, sre;
    logic [AW-1:0] wa0, ra0, wa1, ra1, swa, sra;
    logic [1:0] xo0, xo1, sxo;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    exp_chain_ctl #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .first_slice(1'b1), .exp_in(xo1),
        .wr_req(wr_req), .rd_req(rd_req), .rt_req(rt_req),
        .wr_en(we0), .rd_en(re0), .wr_addr(wa0), .rd_addr(ra0), .exp_out(xo0));

    exp_chain_ctl #(.DEPTH(DEPTH)) u1 (
        .clk(clk), .rst_n(rst_n), .first_slice(1'b0), .exp_in(xo0),
        .wr_req(wr_req), .rd_req(rd_req), .rt_req(rt_req),
        .wr_en(we1), .rd_en(re1), .wr_addr(wa1), .rd_addr(ra1), .exp_out(xo1));

    exp_chain_ctl #(.DEPTH(DEPTH)) u2 (
        .clk(clk), .rst_n(rst_n), .first_slice(1'b0), .exp_in(2'b11),
        .wr_req(s_wr), .rd_req(s_rd), .rt_req(s_rt),
        .wr_en(swe), .rd_en(sre), .wr_addr(swa), .rd_addr(sra), .exp_out(sxo));

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {wr_req, rd_req, rt_req, s_wr, s_rd, s_rt} = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    // Drive single-mode strobes at a falling edge, then let outputs settle.
    task automatic s_drive(input logic w, input logic r, input logic t);
        @(negedge clk);
        s_wr = w; s_rd = r; s_rt = t;
        #1;
    endtask

    initial begin
        do_reset();
        // R1: reset state of ring and single slice
        chk("R1 ring addresses", {wa0, ra0, wa1, ra1}, 0);
        chk("R1 ring exp_out", {xo0, xo1}, 0);
        chk("R1 single exp_out", sxo, 0);

        // Ring walk: R2 R3 R4 R5 R6 R7 R8 R12
        for (int i = 0; i < NV; i++) begin
            vec_t got;
            @(negedge clk);
            wr_req = TBL[i].wr; rd_req = TBL[i].rd; rt_req = TBL[i].rt;
            #1;
            got = '{TBL[i].wr, TBL[i].rd, TBL[i].rt, we0, re0, we1, re1,
                    xo0, xo1, wa0, wa1, ra0, ra1};
            if (got != TBL[i]) $display("step %0d mismatch", i);
            chk("R2 R3 R4 R5 R6 R7 R8 R12 ring step", int'(got), int'(TBL[i]));
        end

        // R1: a fresh reset returns both tokens to the first slice
        do_reset();
        @(negedge clk);
        wr_req = 1'b1; rd_req = 1'b1;
        #1;
        chk("R1 first slice owns tokens", {we0, re0}, 3);
        chk("R1 other slice owns none", {we1, re1}, 0);
        chk("R1 pointers cleared", {wa0, ra0, wa1, ra1}, 0);
        @(negedge clk);
        {wr_req, rd_req} = '0;

        // Single mode: read from empty is blocked (R10)
        s_drive(1'b0, 1'b1, 1'b0);
        chk("R10 read blocked when empty", sre, 0);
        // Fill to full, watching half-full (R9)
        for (int i = 0; i < DEPTH; i++) begin
            s_drive(1'b1, 1'b0, 1'b0);
            chk("R10 write accepted", swe, 1);
            chk("R9 half-full level", sxo, (i > DEPTH / 2) ? 1 : 0);
        end
        s_drive(1'b1, 1'b0, 1'b0);
        chk("R10 write blocked when full", swe, 0);
        chk("R9 half-full at full, bit 1 clear", sxo, 1);
        s_drive(1'b0, 1'b1, 1'b0);
        chk("R10 read accepted when full", sre, 1);
        s_drive(1'b0, 1'b1, 1'b0);
        chk("R9 half-full above half", sxo, 1);
        s_drive(1'b0, 1'b0, 1'b0);
        chk("R9 half-full clears at half", sxo, 0);

        // Retransmit after three writes and two reads (R11)
        do_reset();
        for (int i = 0; i < 3; i++) s_drive(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 2; i++) s_drive(1'b0, 1'b1, 1'b0);
        s_drive(1'b1, 1'b1, 1'b1);
        chk("R11 strobes blocked during retransmit", {swe, sre}, 0);
        chk("R11 count low before retransmit", sxo, 0);
        s_drive(1'b0, 1'b0, 1'b0);
        chk("R11 read address rewound", sra, 0);
        chk("R11 write address kept", swa, 3);
        chk("R11 count restored", sxo, 1);
        for (int i = 0; i < 3; i++) begin
            s_drive(1'b0, 1'b1, 1'b0);
            chk("R11 replayed read accepted", sre, 1);
        end
        s_drive(1'b0, 1'b1, 1'b0);
        chk("R11 replay ends at empty", sre, 0);
        s_drive(1'b0, 1'b0, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule